// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes one received frame at a time and spreads its bytes across a ring of receive descriptors held in system memory. Each descriptor is four 32-bit words: a status word at offset 0 (bit 31 means the engine owns it), a control word at offset 4 (buffer size in bits 10:0, interrupt suppression in bit 31), the buffer address at offset 8 and the address of the following descriptor at offset 12. The engine walks the ring from its current pointer, skips descriptors it does not own or whose buffers are too small, copies bytes into each buffer in turn and writes the status word back with ownership handed over, frame length and first/last markers filled in.

The frame arrives as a header handshake that carries the length, followed by a byte stream. A second header is refused while the current frame is in progress. The engine emits one-cycle interrupt pulses for delivered descriptors and for the case where no usable buffer exists. It also holds the second receive control register, whose start bit drops after each frame it delivers.

Top module: `rx_ring_scatter`

## Requirements
- R1: While `rx_enable` is low when a frame header is accepted, the frame's bytes are consumed and discarded: no memory write, no interrupt pulse, and `ctl1_q` keeps its value.
- R2: A descriptor is usable only when status bit 31 is set and its buffer size (control word bits 10:0) is at least 64; any other descriptor is passed over.
- R3: A search starts at the current pointer and follows next pointers (offset 12); it fails when the address is zero or when a next pointer equals the address the search began at.
- R4: Every descriptor written back has status bit 31 cleared, bits 29:16 replaced by the length value, bit 9 set if it holds the first bytes of the frame, and other bits kept.
- R5: When buffer size is below remaining bytes plus 4, the engine writes min(size, remaining) bytes and stores the buffer size as length, bit 8 untouched.
- R6: Otherwise the descriptor ends the frame: the remaining bytes are written, bit 8 is set and the length is remaining+4, or 68 when fewer than 64 bytes remain.
- R7: After each status write-back, `irq_rx` pulses for one cycle unless control word bit 31 of that descriptor is set.
- R8: Any failed search (frame start, mid-frame or after the last descriptor) pulses `irq_nobuf`, resets the current pointer to the ring head, and discards the frame's unwritten bytes.
- R9: `ctl1_q` resets to 0x2; a write stores the data with bit 1 forced to 1; bit 31 is cleared when an enabled frame finishes.
- R10: `frm_ready` is low from header acceptance until the frame is finished, and `byte_ready` is only high during that time.
- R11: A memory request not yet taken with `mem_ready` keeps its address and direction in the next cycle.
- R12: A ring base write sets both head and current pointer; after each descriptor, the next search starts at that descriptor's next pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_enable | input | 1 | Receive enable, sampled at header acceptance |
| ring_base_wr | input | 1 | Load ring head and current pointer |
| ring_base | input | AW | Ring base address |
| ctl1_wr | input | 1 | Write strobe for receive control 1 |
| ctl1_wdata | input | 32 | Write data for receive control 1 |
| ctl1_q | output | 32 | Receive control 1 contents |
| frm_valid | input | 1 | Frame header valid |
| frm_len | input | LW | Frame length in bytes |
| frm_ready | output | 1 | Header accepted when high with frm_valid |
| byte_valid | input | 1 | Frame byte valid |
| byte_data | input | 8 | Frame byte |
| byte_ready | output | 1 | Byte taken when high with byte_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the request in this cycle |
| irq_rx | output | 1 | Descriptor delivered pulse |
| irq_nobuf | output | 1 | No usable descriptor pulse |

## Verification
Interrupt pulses come from registers, so `irq_rx` shows one cycle after the status write is taken and `irq_nobuf` one cycle after the failing evaluation; the bench counts them at falling edges and compares per frame with a behavioural ring model. The start bit of `ctl1_q` drops one cycle after the finishing state, which comes before `frm_ready` rises again, so the bench samples memory, counts and `ctl1_q` a few falling edges after `frm_ready` returns. Register writes are checked at the falling edge after the write edge, and the busy rule is checked on every byte handshake.

// File: rtl/rx_scatter_pkg.sv
package rx_scatter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRCH,
        ST_EVAL,
        ST_DATA,
        ST_STAT,
        ST_DRAIN,
        ST_DONE
    } scat_st_e;

    localparam int OWN_BIT        = 31;
    localparam int QUIET_BIT      = 31;
    localparam int FIRST_BIT      = 9;
    localparam int LAST_BIT       = 8;
    localparam int LEN_LSB        = 16;
    localparam int LEN_W          = 14;
    localparam int SIZE_W         = 11;
    localparam int MIN_BUF        = 64;
    localparam int FCS_BYTES      = 4;
    localparam int CTL1_START_BIT = 31;
    localparam int CTL1_FIXED_BIT = 1;
    localparam logic [31:0] CTL1_RESET = 32'h0000_0002;

endpackage

// File: rtl/rx_fill_calc.sv
module rx_fill_calc
    import rx_scatter_pkg::*;
#(
    parameter int LW = 14
) (
    input  logic [31:0]       stat_in,
    input  logic [SIZE_W-1:0] size,
    input  logic [LW-1:0]     left,
    input  logic              first,
    output logic              usable,
    output logic [SIZE_W-1:0] fill_bytes,
    output logic [31:0]       stat_out
);
    localparam int XW = ((LW > SIZE_W) ? LW : SIZE_W) + 1;

    logic [XW-1:0] need;
    logic [XW-1:0] len_val;
    logic          partial;

    always_comb begin
        usable  = stat_in[OWN_BIT] && (XW'(size) >= XW'(MIN_BUF));
        need    = XW'(left) + XW'(FCS_BYTES);
        partial = XW'(size) < need;
        if (partial) begin
            fill_bytes = (XW'(size) < XW'(left)) ? size : SIZE_W'(left);
            len_val    = XW'(size);
        end else begin
            fill_bytes = SIZE_W'(left);
            len_val    = (XW'(left) < XW'(MIN_BUF)) ? XW'(MIN_BUF + FCS_BYTES)
                                                    : need;
        end
        stat_out                          = stat_in;
        stat_out[OWN_BIT]                 = 1'b0;
        stat_out[LEN_LSB +: LEN_W]        = LEN_W'(len_val);
        stat_out[FIRST_BIT]               = stat_in[FIRST_BIT] | first;
        stat_out[LAST_BIT]                = stat_in[LAST_BIT] | ~partial;
    end

endmodule

// File: rtl/rx_ctl1_reg.sv
module rx_ctl1_reg
    import rx_scatter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        clr_start,
    output logic [31:0] q
);
    logic [31:0] ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (clr_start) ctl_d[CTL1_START_BIT] = 1'b0;
        if (wr) begin
            ctl_d                 = wdata;
            ctl_d[CTL1_FIXED_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL1_RESET;
        else        ctl_q <= ctl_d;
    end

    assign q = ctl_q;

endmodule

// File: rtl/rx_ring_scatter.sv
module rx_ring_scatter
    import rx_scatter_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          ring_base_wr,
    input  logic [AW-1:0] ring_base,
    input  logic          ctl1_wr,
    input  logic [31:0]   ctl1_wdata,
    output logic [31:0]   ctl1_q,
    input  logic          frm_valid,
    input  logic [LW-1:0] frm_len,
    output logic          frm_ready,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    output logic          byte_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    output logic          irq_rx,
    output logic          irq_nobuf
);
    localparam int WORDS = 4;
    localparam int WIDX_W = $clog2(WORDS);

    typedef struct packed {
        scat_st_e          st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     head;
        logic [AW-1:0]     start;
        logic [AW-1:0]     addr;
        logic [WIDX_W-1:0] widx;
        logic [31:0]       w0;
        logic [SIZE_W-1:0] sz;
        logic              quiet;
        logic [AW-1:0]     bufa;
        logic [AW-1:0]     nxt;
        logic [31:0]       stat;
        logic [LW-1:0]     left;
        logic [SIZE_W-1:0] dbytes;
        logic [SIZE_W-1:0] boff;
        logic              first;
        logic              en;
        logic              irq_rx;
        logic              irq_nb;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              usable;
    logic [SIZE_W-1:0] fill_bytes;
    logic [31:0]       stat_new;
    logic              clr_start;

    rx_fill_calc #(.LW(LW)) u_fill (
        .stat_in    (eng_q.w0),
        .size       (eng_q.sz),
        .left       (eng_q.left),
        .first      (eng_q.first),
        .usable     (usable),
        .fill_bytes (fill_bytes),
        .stat_out   (stat_new)
    );

    rx_ctl1_reg u_ctl1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl1_wr),
        .wdata     (ctl1_wdata),
        .clr_start (clr_start),
        .q         (ctl1_q)
    );

    always_comb begin
        eng_d        = eng_q;
        eng_d.irq_rx = 1'b0;
        eng_d.irq_nb = 1'b0;
        frm_ready    = 1'b0;
        byte_ready   = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_be       = 4'h0;
        mem_wdata    = '0;
        clr_start    = 1'b0;

        case (eng_q.st)
            ST_IDLE: begin
                frm_ready = 1'b1;
                if (frm_valid) begin
                    eng_d.left  = frm_len;
                    eng_d.en    = rx_enable;
                    eng_d.first = 1'b1;
                    eng_d.start = eng_q.cur;
                    eng_d.addr  = eng_q.cur;
                    eng_d.widx  = '0;
                    eng_d.st    = rx_enable ? ST_SRCH : ST_DRAIN;
                end
            end
            ST_SRCH: begin
                if (eng_q.addr == '0) begin
                    eng_d.irq_nb = 1'b1;
                    eng_d.cur    = eng_q.head;
                    eng_d.st     = (eng_q.left != '0) ? ST_DRAIN : ST_DONE;
                end else begin
                    mem_req  = 1'b1;
                    mem_be   = 4'hF;
                    mem_addr = eng_q.addr + AW'({eng_q.widx, 2'b00});
                    if (mem_ready) begin
                        case (eng_q.widx)
                            2'd0: eng_d.w0 = mem_rdata;
                            2'd1: begin
                                eng_d.sz    = mem_rdata[SIZE_W-1:0];
                                eng_d.quiet = mem_rdata[QUIET_BIT];
                            end
                            2'd2: eng_d.bufa = mem_rdata[AW-1:0];
                            default: eng_d.nxt = mem_rdata[AW-1:0];
                        endcase
                        eng_d.widx = eng_q.widx + 1'b1;
                        if (eng_q.widx == WIDX_W'(WORDS - 1)) eng_d.st = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (usable) begin
                    eng_d.cur = eng_q.addr;
                    if (eng_q.left == '0) begin
                        eng_d.st = ST_DONE;
                    end else begin
                        eng_d.dbytes = fill_bytes;
                        eng_d.stat   = stat_new;
                        eng_d.boff   = '0;
                        eng_d.st     = ST_DATA;
                    end
                end else if (eng_q.nxt == eng_q.start || eng_q.nxt == '0) begin
                    eng_d.irq_nb = 1'b1;
                    eng_d.cur    = eng_q.head;
                    eng_d.st     = (eng_q.left != '0) ? ST_DRAIN : ST_DONE;
                end else begin
                    eng_d.addr = eng_q.nxt;
                    eng_d.widx = '0;
                    eng_d.st   = ST_SRCH;
                end
            end
            ST_DATA: begin
                mem_req    = byte_valid;
                mem_we     = 1'b1;
                mem_addr   = eng_q.bufa + AW'(eng_q.boff);
                mem_be     = 4'b0001 << mem_addr[1:0];
                mem_wdata  = {4{byte_data}};
                byte_ready = mem_ready;
                if (byte_valid && mem_ready) begin
                    eng_d.boff = eng_q.boff + 1'b1;
                    eng_d.left = eng_q.left - 1'b1;
                    if (eng_q.boff + 1'b1 == eng_q.dbytes) eng_d.st = ST_STAT;
                end
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_addr  = eng_q.cur;
                mem_wdata = eng_q.stat;
                if (mem_ready) begin
                    eng_d.irq_rx = ~eng_q.quiet;
                    eng_d.first  = 1'b0;
                    eng_d.start  = eng_q.nxt;
                    eng_d.addr   = eng_q.nxt;
                    eng_d.widx   = '0;
                    eng_d.st     = ST_SRCH;
                end
            end
            ST_DRAIN: begin
                byte_ready = 1'b1;
                if (eng_q.left == '0) begin
                    eng_d.st = eng_q.en ? ST_DONE : ST_IDLE;
                end else if (byte_valid) begin
                    eng_d.left = eng_q.left - 1'b1;
                    if (eng_q.left == LW'(1)) eng_d.st = eng_q.en ? ST_DONE : ST_IDLE;
                end
            end
            ST_DONE: begin
                clr_start = 1'b1;
                eng_d.st  = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase

        if (ring_base_wr) begin
            eng_d.head = ring_base;
            eng_d.cur  = ring_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign irq_rx    = eng_q.irq_rx;
    assign irq_nobuf = eng_q.irq_nb;

endmodule

// File: rtl/rx_ring_scatter_chk.sv
module rx_ring_scatter_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_ready,
    input logic          byte_ready,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   ctl1_q,
    input logic          irq_rx,
    input logic          irq_nobuf
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_mem_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !frm_ready);

    assert_byte_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> !frm_ready);

    assert_fixed_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_q[1]);

    assert_irq_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rx, irq_nobuf}));

    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);

endmodule

bind rx_ring_scatter rx_ring_scatter_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_ready  (frm_ready),
    .byte_ready (byte_ready),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .ctl1_q     (ctl1_q),
    .irq_rx     (irq_rx),
    .irq_nobuf  (irq_nobuf)
);

// File: tb/rx_ring_scatter_test.sv
module rx_ring_scatter_test;
    localparam int AW = 32;
    localparam int LW = 14;
    localparam int MW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_enable = 1'b0;
    logic          ring_base_wr = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          ctl1_wr = 1'b0;
    logic [31:0]   ctl1_wdata = '0;
    logic [31:0]   ctl1_q;
    logic          frm_valid = 1'b0;
    logic [LW-1:0] frm_len = '0;
    logic          frm_ready;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          byte_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          mem_ready = 1'b1;
    logic          irq_rx, irq_nobuf;

    int checks = 0;
    int errors = 0;
    int cnt_rx = 0;
    int cnt_nb = 0;

    logic [31:0] mem [0:MW-1];
    logic [31:0] exp_mem [0:MW-1];
    int          m_head = 0, m_cur = 0, m_rx = 0, m_nb = 0;
    logic [31:0] exp_ctl1 = 32'h2;

    always #5 clk = ~clk;

    rx_ring_scatter #(.AW(AW), .LW(LW)) uut (.*);

    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk)
        if (mem_req && mem_ready && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];

    always @(negedge clk) begin
        if (irq_rx) cnt_rx++;
        if (irq_nobuf) cnt_nb++;
    end

    initial begin
        logic [7:0] lf = 8'h5a;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mem_ready = (lf[1:0] != 2'b00);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int i);
        return 8'((seed * 31) + (i * 7) + 3);
    endfunction

    function automatic logic [31:0] ew(input int a);
        return exp_mem[(a >> 2) % MW];
    endfunction

    task automatic put_word(input int a, input logic [31:0] v);
        mem[(a >> 2) % MW] = v;
        exp_mem[(a >> 2) % MW] = v;
    endtask

    task automatic set_desc(input int a, input bit own, input int size, input bit quiet,
                            input int bufa, input int nxt);
        put_word(a, own ? 32'h8000_0000 : 32'h0);
        put_word(a + 4, {quiet, 20'h0, 11'(size)});
        put_word(a + 8, 32'(bufa));
        put_word(a + 12, 32'(nxt));
    endtask

    // Behavioural ring model written from the requirements
    task automatic m_find(input int start, output int res);
        int a = start;
        res = 0;
        for (int g = 0; g < 64 && a != 0; g++) begin
            if (ew(a)[31] && ew(a + 4)[10:0] >= 64) begin
                res = a;
                return;
            end
            if (int'(ew(a + 12)) == start) return;
            a = int'(ew(a + 12));
        end
    endtask

    task automatic m_frame(input int len, input int seed);
        int left = len, f, sz, db, ln, ba;
        bit frst = 1'b1, last;
        logic [31:0] st;
        m_find(m_cur, f);
        if (f == 0) begin
            m_nb++;
            m_cur = m_head;
            return;
        end
        m_cur = f;
        while (left > 0) begin
            sz = int'(ew(f + 4)[10:0]);
            ba = int'(ew(f + 8));
            if (sz < left + 4) begin
                db = (sz < left) ? sz : left;
                ln = sz;
                last = 1'b0;
            end else begin
                db = left;
                ln = (left < 64) ? 68 : left + 4;
                last = 1'b1;
            end
            for (int k = 0; k < db; k++) begin
                int ad = ba + k;
                exp_mem[(ad >> 2) % MW][(ad % 4) * 8 +: 8] = bval(seed, len - left + k);
            end
            st = ew(f);
            st[31] = 1'b0;
            st[29:16] = 14'(ln);
            if (frst) st[9] = 1'b1;
            if (last) st[8] = 1'b1;
            exp_mem[(f >> 2) % MW] = st;
            if (!ew(f + 4)[31]) m_rx++;
            left -= db;
            frst = 1'b0;
            m_find(int'(ew(f + 12)), f);
            if (f == 0) begin
                m_nb++;
                m_cur = m_head;
                return;
            end
            m_cur = f;
        end
    endtask

    task automatic wr_ctl1(input logic [31:0] v);
        @(negedge clk);
        ctl1_wr = 1'b1;
        ctl1_wdata = v;
        @(posedge clk);
        #1 ctl1_wr = 1'b0;
        exp_ctl1 = v | 32'h2;
    endtask

    task automatic set_base(input int a);
        @(negedge clk);
        ring_base_wr = 1'b1;
        ring_base = AW'(a);
        @(posedge clk);
        #1 ring_base_wr = 1'b0;
        m_head = a;
        m_cur = a;
    endtask

    task automatic run_frame(input int len, input int seed, input bit en, input string tag);
        int rx0 = cnt_rx, nb0 = cnt_nb, mrx0, mnb0, bad = 0;
        bit busy_bad = 1'b0;
        wr_ctl1(32'h8000_0000);
        mrx0 = m_rx;
        mnb0 = m_nb;
        if (en) begin
            m_frame(len, seed);
            exp_ctl1[31] = 1'b0;
        end
        @(negedge clk);
        rx_enable = en;
        frm_valid = 1'b1;
        frm_len = LW'(len);
        while (!frm_ready) @(negedge clk);
        @(posedge clk);
        #1 frm_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data = bval(seed, i);
            if (frm_ready) busy_bad = 1'b1;
            while (!byte_ready) begin
                @(negedge clk);
                if (frm_ready) busy_bad = 1'b1;
            end
            @(posedge clk);
            #1;
        end
        byte_valid = 1'b0;
        @(negedge clk);
        while (!frm_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int w = 0; w < MW; w++) if (mem[w] !== exp_mem[w]) begin
            if (bad == 0) chk(1'b0, {tag, " memory image"}, mem[w], exp_mem[w]);
            bad++;
        end
        if (bad == 0) chk(1'b1, tag, 0, 0);
        chk(cnt_rx - rx0 == m_rx - mrx0, "R7 rx pulses", cnt_rx - rx0, m_rx - mrx0);
        chk(cnt_nb - nb0 == m_nb - mnb0, "R8 nobuf pulses", cnt_nb - nb0, m_nb - mnb0);
        chk(ctl1_q == exp_ctl1, "R9 ctl1 after frame", ctl1_q, exp_ctl1);
        chk(!busy_bad, "R10 header held off", busy_bad, 0);
    endtask

    initial begin
        for (int w = 0; w < MW; w++) put_word(w * 4, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl1_q == 32'h2, "R9 reset value", ctl1_q, 32'h2);
        chk(frm_ready == 1'b1, "R10 idle ready", frm_ready, 1);
        chk(irq_rx == 1'b0, "R7 reset pulse", irq_rx, 0);
        chk(irq_nobuf == 1'b0, "R8 reset pulse", irq_nobuf, 0);
        chk(mem_req == 1'b0, "R11 reset request", mem_req, 0);

        wr_ctl1(32'h8000_0000);
        @(negedge clk);
        chk(ctl1_q == 32'h8000_0002, "R9 forced bit", ctl1_q, 32'h8000_0002);
        wr_ctl1(32'h0);
        @(negedge clk);
        chk(ctl1_q == 32'h2, "R9 forced bit zero write", ctl1_q, 32'h2);

        // Ring: D1 too small (R2), D2 quiet (R7)
        set_desc(32'h100, 1, 128, 0, 32'h400, 32'h110);
        set_desc(32'h110, 1, 32,  0, 32'h500, 32'h120);
        set_desc(32'h120, 1, 128, 1, 32'h600, 32'h130);
        set_desc(32'h130, 1, 128, 0, 32'h700, 32'h140);
        set_desc(32'h140, 1, 100, 0, 32'h800, 32'h100);
        set_base(32'h100);

        run_frame(40, 1, 1, "R6 short frame");
        chk(mem[32'h100 >> 2] == 32'h0044_0300, "R6 short status", mem[32'h100 >> 2], 32'h0044_0300);
        run_frame(200, 2, 1, "R12 two descriptors");
        chk(mem[32'h120 >> 2] == 32'h0080_0200, "R4 fill status", mem[32'h120 >> 2], 32'h0080_0200);
        run_frame(96, 3, 1, "R3 ring exhausted after last");
        run_frame(50, 4, 0, "R1 disabled drop");

        set_desc(32'h100, 1, 128, 0, 32'h400, 32'h110);
        set_desc(32'h120, 1, 128, 0, 32'h600, 32'h130);
        run_frame(126, 5, 1, "R5 partial fill");
        chk(mem[32'h100 >> 2] == 32'h0080_0200, "R5 no last flag", mem[32'h100 >> 2], 32'h0080_0200);
        run_frame(64, 6, 1, "R2 small buffer skipped");
        chk(mem[32'h120 >> 2] == 32'h0044_0300, "R6 exact 64", mem[32'h120 >> 2], 32'h0044_0300);

        set_desc(32'h100, 1, 64, 0, 32'h400, 32'h110);
        set_desc(32'h120, 1, 64, 0, 32'h600, 32'h130);
        run_frame(200, 7, 1, "R8 mid-frame abandon");

        set_base(0);
        run_frame(30, 8, 1, "R3 zero pointer");

        set_base(32'h100);
        set_desc(32'h100, 1, 128, 0, 32'h400, 32'h110);
        run_frame(124, 9, 1, "R6 size equals remaining plus four");
        chk(mem[32'h100 >> 2] == 32'h0080_0300, "R6 boundary status", mem[32'h100 >> 2], 32'h0080_0300);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule